// File: doc/BRIEF.md
# Critical-Word-First Beat Sequencer

When a cache miss fetches a 64-byte line over a data path narrower than the line, this block decides the order in which the line's beats are requested. It accepts one request carrying the line address and the byte offset of the load that missed. It then issues beat indices one per handshake. The first index is the beat holding the demanded 8-byte word. The others follow in rising address order and wrap to the start of the line, so the waiting load can restart as soon as the first beat returns.

A mode input chooses between a narrow data path (16 bytes, four beats per line) and a wide one (32 bytes, two beats per line). The mode is sampled together with the request. The block holds one burst at a time and refuses a new request until the current burst has handed over its final beat.

Top module: `cwf_burst_seq`

## Requirements
- R1: After reset, `beat_valid` is low and `req_ready` is high.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from that edge until the burst ends, and a request presented while it is low is ignored.
- R3: The first beat is valid in the cycle after acceptance. Its index is the critical beat: `req_offset[5:4]` when `req_wide` is 0 (16-byte beats), or `req_offset[5]` when `req_wide` is 1 (32-byte beats).
- R4: Each beat after the first has the index of the previous beat plus one, modulo the number of beats in the line.
- R5: A burst has exactly 4 beats in narrow mode and 2 in wide mode. `beat_last` is high on the final beat only.
- R6: While `beat_valid` is high and `beat_ready` is low, `beat_idx`, `beat_last` and `beat_line` keep their values.
- R7: In the cycle after the final beat is handed over, `beat_valid` is low and `req_ready` is high.
- R8: The mode and the line address are captured when the request is taken. `beat_line` shows the captured address throughout the burst, whatever the request inputs do later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A miss request is offered |
| req_ready | output | 1 | The sequencer is idle and can take a request |
| req_line | input | LINE_ADDR_W | Line address of the miss |
| req_offset | input | 6 | Byte offset of the demanded word within the line |
| req_wide | input | 1 | 1: 32-byte beats, 0: 16-byte beats |
| beat_valid | output | 1 | A beat index is presented |
| beat_ready | input | 1 | The consumer takes the beat |
| beat_idx | output | 2 | Beat number within the line, counted from byte 0 |
| beat_last | output | 1 | This beat ends the burst |
| beat_line | output | LINE_ADDR_W | Line address of the burst in progress |

## Verification
The first beat is due one edge after a request is accepted. Every later beat is due one edge after the previous beat's handshake. The idle state returns one edge after the final handshake. The bench drives its inputs on falling edges and reads the outputs just after the next falling edge, so each reading sees exactly one rising edge since the stimulus. Stall cycles are read repeatedly to confirm the outputs hold. Every value of `req_offset` is swept in both modes, with varying stall lengths, and junk requests are injected during stalls.

// File: rtl/cwf_pkg.sv
// Package: shared encodings for the critical-word-first sequencer.
// Assumes: beat widths are powers of two that divide the line size.
package cwf_pkg;
    typedef enum logic {
        BEAT_NARROW = 1'b0,
        BEAT_WIDE   = 1'b1
    } beat_mode_e;
endpackage

// File: rtl/cwf_start_calc.sv
// Module: cwf_start_calc
// Finds the beat that holds the demanded word and the wrap mask (beat count
// minus one) for the selected data-path width. Purely combinational.
// Assumes: NARROW_SHIFT < WIDE_SHIFT <= OFF_W.
module cwf_start_calc #(
    parameter int OFF_W        = 6,
    parameter int IDX_W        = 2,
    parameter int NARROW_SHIFT = 4,
    parameter int WIDE_SHIFT   = 5
) (
    input  logic [OFF_W-1:0]  offset,
    input  cwf_pkg::beat_mode_e mode,
    output logic [IDX_W-1:0]  start_idx,
    output logic [IDX_W-1:0]  wrap_mask
);
    localparam int NARROW_BEATS = 1 << (OFF_W - NARROW_SHIFT);
    localparam int WIDE_BEATS   = 1 << (OFF_W - WIDE_SHIFT);

    // Purpose: divide the offset by the beat width and pick the beat count.
    always_comb begin
        if (mode == cwf_pkg::BEAT_WIDE) begin
            start_idx = IDX_W'(offset >> WIDE_SHIFT);
            wrap_mask = IDX_W'(WIDE_BEATS - 1);
        end else begin
            start_idx = IDX_W'(offset >> NARROW_SHIFT);
            wrap_mask = IDX_W'(NARROW_BEATS - 1);
        end
    end
endmodule

// File: rtl/cwf_beat_counter.sv
// Module: cwf_beat_counter
// Holds the burst state: busy flag, current beat index, beats issued so far
// and the wrap mask. Loads on request acceptance and steps on each handshake.
// Assumes: load is only pulsed while not busy; advance only while busy.
module cwf_beat_counter #(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] start_idx,
    input  logic [IDX_W-1:0] wrap_mask,
    input  logic             advance,
    output logic             busy,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    logic [IDX_W-1:0] issued_q;
    logic [IDX_W-1:0] mask_q;

    // Purpose: final beat when the issued count reaches the mask.
    always_comb last = busy && (issued_q == mask_q);

    // Purpose: load a burst, step the wrapping index, end after the last beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            idx      <= '0;
            issued_q <= '0;
            mask_q   <= '0;
        end else if (load) begin
            busy     <= 1'b1;
            idx      <= start_idx;
            issued_q <= '0;
            mask_q   <= wrap_mask;
        end else if (advance) begin
            if (last) begin
                busy <= 1'b0;
            end else begin
                idx      <= (idx + 1'b1) & mask_q;
                issued_q <= issued_q + 1'b1;
            end
        end
    end

    // R4: the index never leaves the range of beats of the current mode.
    a_r4_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((idx & ~mask_q) == '0));

    // R5: a step that is not the last leaves the burst running.
    a_r5_not_last_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && busy && !last) |=> busy);
endmodule

// File: rtl/cwf_burst_seq.sv
// Module: cwf_burst_seq (top)
// Critical-word-first beat sequencer for one cache line. Accepts a miss
// request when idle, then issues beat indices starting at the beat holding
// the demanded word, wrapping modulo the beat count.
// Assumes: LINE_BYTES, NARROW_BYTES and WIDE_BYTES are powers of two.
module cwf_burst_seq #(
    parameter int LINE_ADDR_W  = 26,
    parameter int LINE_BYTES   = 64,
    parameter int NARROW_BYTES = 16,
    parameter int WIDE_BYTES   = 32,
    localparam int OFF_W       = $clog2(LINE_BYTES),
    localparam int IDX_W       = $clog2(LINE_BYTES / NARROW_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [LINE_ADDR_W-1:0] req_line,
    input  logic [OFF_W-1:0]       req_offset,
    input  logic                   req_wide,
    output logic                   beat_valid,
    input  logic                   beat_ready,
    output logic [IDX_W-1:0]       beat_idx,
    output logic                   beat_last,
    output logic [LINE_ADDR_W-1:0] beat_line
);
    localparam int NARROW_SHIFT = $clog2(NARROW_BYTES);
    localparam int WIDE_SHIFT   = $clog2(WIDE_BYTES);

    logic             busy;
    logic             accept;
    logic             step;
    logic [IDX_W-1:0] start_idx;
    logic [IDX_W-1:0] wrap_mask;
    logic [LINE_ADDR_W-1:0] line_q;
    cwf_pkg::beat_mode_e    mode_in;

    // Purpose: decode handshakes at both edges of the block.
    always_comb begin
        mode_in    = req_wide ? cwf_pkg::BEAT_WIDE : cwf_pkg::BEAT_NARROW;
        req_ready  = !busy;
        accept     = req_valid && req_ready;
        beat_valid = busy;
        step       = beat_valid && beat_ready;
        beat_line  = line_q;
    end

    cwf_start_calc #(
        .OFF_W(OFF_W), .IDX_W(IDX_W),
        .NARROW_SHIFT(NARROW_SHIFT), .WIDE_SHIFT(WIDE_SHIFT)
    ) u_start (
        .offset(req_offset), .mode(mode_in),
        .start_idx(start_idx), .wrap_mask(wrap_mask)
    );

    cwf_beat_counter #(.IDX_W(IDX_W)) u_count (
        .clk(clk), .rst_n(rst_n),
        .load(accept), .start_idx(start_idx), .wrap_mask(wrap_mask),
        .advance(step), .busy(busy), .idx(beat_idx), .last(beat_last)
    );

    // Purpose: capture the line address of an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)      line_q <= '0;
        else if (accept) line_q <= req_line;
    end

    // R3: the first beat after acceptance is the critical one.
    a_r3_first_is_critical: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (beat_valid && beat_idx == $past(start_idx)));

    // R6: a stalled beat holds its index, last flag and line.
    a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_ready) |=>
            (beat_valid && $stable(beat_idx) && $stable(beat_last) && $stable(beat_line)));

    // R7: a handed-over final beat returns the sequencer to idle.
    a_r7_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (step && beat_last) |=> (!beat_valid && req_ready));

    // R2: no request is taken while a burst is presented.
    a_r2_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> !req_ready);

    // R8: the line address stays fixed during a burst.
    a_r8_line_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && $past(beat_valid)) |-> $stable(beat_line));
endmodule

// File: tb/cwf_burst_seq_bench.sv
module cwf_burst_seq_bench;
    localparam int AW = 26;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic          req_ready;
    logic [AW-1:0] req_line;
    logic [5:0]    req_offset;
    logic          req_wide;
    logic          beat_valid;
    logic          beat_ready;
    logic [1:0]    beat_idx;
    logic          beat_last;
    logic [AW-1:0] beat_line;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    cwf_burst_seq u_cwf_burst_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_line(req_line), .req_offset(req_offset), .req_wide(req_wide),
        .beat_valid(beat_valid), .beat_ready(beat_ready),
        .beat_idx(beat_idx), .beat_last(beat_last), .beat_line(beat_line)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // One burst: request at a falling edge, then walk every beat with stalls.
    task automatic run_burst(input int off, input bit wide, input int stall_seed,
                             input logic [AW-1:0] line);
        int beats;
        int crit;
        beats = wide ? 2 : 4;
        crit  = wide ? off / 32 : off / 16;
        @(negedge clk);
        req_valid  = 1'b1;
        req_offset = 6'(off);
        req_wide   = wide;
        req_line   = line;
        beat_ready = 1'b0;
        #1 check(req_ready == 1'b1, "R2 ready when idle", int'(req_ready), 1);
        for (int k = 0; k < beats; k++) begin
            int stalls;
            int exp_idx;
            stalls  = (stall_seed + k) % 3;
            exp_idx = (crit + k) % beats;
            for (int s = 0; s <= stalls; s++) begin
                @(negedge clk);
                if (s < stalls) begin
                    // junk request during a stall must be ignored (R2, R8)
                    req_valid  = 1'b1;
                    req_offset = 6'(off + 16);
                    req_wide   = ~wide;
                    req_line   = ~line;
                    beat_ready = 1'b0;
                end else begin
                    req_valid  = 1'b0;
                    beat_ready = 1'b1;
                end
                #1;
                check(beat_valid == 1'b1, "R3 beat valid", int'(beat_valid), 1);
                if (k == 0)
                    check(int'(beat_idx) == exp_idx, "R3 critical beat first", int'(beat_idx), exp_idx);
                else if (s == 0)
                    check(int'(beat_idx) == exp_idx, "R4 wrapping order", int'(beat_idx), exp_idx);
                else
                    check(int'(beat_idx) == exp_idx, "R6 index held on stall", int'(beat_idx), exp_idx);
                check(beat_last == (k == beats - 1), "R5 last flag", int'(beat_last), int'(k == beats - 1));
                check(beat_line == line, "R8 captured line", int'(beat_line), int'(line));
                check(req_ready == 1'b0, "R2 busy refuses requests", int'(req_ready), 0);
            end
        end
        @(negedge clk);
        beat_ready = 1'b0;
        req_valid  = 1'b0;
        #1;
        check(beat_valid == 1'b0, "R7 idle after last beat", int'(beat_valid), 0);
        check(req_ready == 1'b1, "R7 ready after last beat", int'(req_ready), 1);
    endtask

    initial begin
        rst_n      = 1'b0;
        req_valid  = 1'b0;
        req_line   = '0;
        req_offset = '0;
        req_wide   = 1'b0;
        beat_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(beat_valid == 1'b0, "R1 reset no valid", int'(beat_valid), 0);
        check(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
        // R3 R4 R5: the worked example, narrow mode, bytes 32-39 -> 2,3,0,1
        run_burst(32, 1'b0, 0, 26'h0ABCDE);
        for (int w = 0; w < 2; w++) begin
            for (int off = 0; off < 64; off++) begin
                run_burst(off, w[0], off + w, 26'(off * 7919 + w * 123457));
            end
        end
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end
endmodule